// File: doc/BRIEF.md
# Multicycle Multiply-Divide Unit

This unit sits beside a 32-bit integer core and carries out the arithmetic that needs more than one cycle. It holds a 64-bit result pair, made of a high word HI and a low word LO. It supports the following operations:

- signed and unsigned 32x32 multiply into HI:LO;
- signed and unsigned multiply-add and multiply-subtract into HI:LO;
- a three-operand multiply that keeps only the low word;
- signed and unsigned divide;
- direct writes of either HI or LO.

Each operation has a fixed latency. Unsigned forms take the shorter count. Signed forms take one more cycle to correct the sign. Signed accumulation can clamp on overflow, and a sticky flag records that an overflow happened.

The core sends work on an operation stream made of `op_valid`, `op_ready`, `op_code`, `op_a`, `op_b` and `op_sat`. It reads results on a read stream made of `rd_valid`, `rd_sel`, `rd_ready` and `rd_data`. Both `ready` outputs are low for every cycle in which `busy` is high:

- A pending operation or read simply waits, holding its inputs, until `ready` returns.
- A transfer happens on a rising clock edge where `valid` and `ready` are both high.
- `rd_data` is combinational. It shows the selected register whenever `rd_valid` is high, and shows zero when `rd_valid` is low.

The core keeps instruction decode, interlock and register writeback.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy` and `ovf_flag` are 0, both ready outputs are 1, and reads of HI (`rd_sel`=1) and LO (`rd_sel`=0) return 0.
- R2: Opcode 0 (signed) and opcode 1 (unsigned) write the full 64-bit product of `op_a` and `op_b` into HI:LO.
- R3: After a multiply-family operation (opcodes 0 to 6) is accepted, `busy` stays high for exactly 4 cycles for unsigned opcodes (1, 3, 5) and 5 cycles for signed opcodes (0, 2, 4, 6). HI and LO change only on the edge where `busy` falls.
- R4: After a divide is accepted, `busy` stays high for exactly 34 cycles for opcode 8 (unsigned) and 35 cycles for opcode 7 (signed).
- R5: Division puts the quotient, truncated toward zero, in LO and the remainder in HI. The remainder carries the sign of the dividend. Dividing the most negative value by -1 gives LO=0x80000000 and HI=0.
- R6: Division by zero completes in the normal cycle count and raises nothing. For unsigned division by zero, LO becomes 0xFFFFFFFF and HI becomes the dividend.
- R7: Opcodes 2 and 3 add the product to HI:LO, and opcodes 4 and 5 subtract it. The arithmetic is modulo 2^64. Opcodes 2 and 4 use signed operands; opcodes 3 and 5 use unsigned operands.
- R8: A signed accumulate (opcode 2 or 4) whose true result lies outside the 64-bit signed range sets `ovf_flag`, and the flag stays set until reset. If `op_sat` was 1 when the operation was accepted, the result is clamped to 0x7FFF_FFFF_FFFF_FFFF or 0x8000_0000_0000_0000, following the overflow direction. Otherwise the result wraps.
- R9: Opcode 6 writes the low 32 bits of the signed product into LO and leaves HI unchanged.
- R10: Opcode 9 writes `op_a` into HI and opcode 10 writes `op_a` into LO. Each write takes effect on the accepting edge, leaves the other half unchanged, and never raises `busy`.
- R11: While `busy` is high, `op_ready` and `rd_ready` are 0. An `op_valid` held during that time has no effect on HI, LO or the running operation.
- R12: Opcodes 11 to 15 are accepted but change neither HI, LO, `busy` nor `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Unit can take an operation |
| op_code | input | 4 | Operation code |
| op_a | input | 32 | First operand, dividend, or value to move |
| op_b | input | 32 | Second operand or divisor |
| op_sat | input | 1 | Clamp signed accumulate on overflow |
| busy | output | 1 | A multicycle operation is in flight |
| ovf_flag | output | 1 | Sticky signed-accumulate overflow |
| rd_valid | input | 1 | Read request |
| rd_sel | input | 1 | 1 selects HI, 0 selects LO |
| rd_ready | output | 1 | Read data is current |
| rd_data | output | 32 | Selected register value |

## Verification
The bench measures how long `busy` stays high for every operation, so it would report a design that applies the extra sign cycle to unsigned forms, or that skips it for signed forms. It divides operands of mixed signs and the most-negative-by-minus-one case, which would expose a design that rounds toward minus infinity or takes the remainder's sign from the divisor. It drives signed accumulations past both ends of the 64-bit range with and without clamping, which would catch a design that clamps in the wrong direction, clamps when it should wrap, or lets the overflow flag clear. It also holds a register write on the operation port while a divide is running, which shows whether a design lets that write through.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [3:0] {
    OPC_MUL_S  = 4'd0,
    OPC_MUL_U  = 4'd1,
    OPC_MAC_S  = 4'd2,
    OPC_MAC_U  = 4'd3,
    OPC_MSB_S  = 4'd4,
    OPC_MSB_U  = 4'd5,
    OPC_MUL_LO = 4'd6,
    OPC_DIV_S  = 4'd7,
    OPC_DIV_U  = 4'd8,
    OPC_SET_HI = 4'd9,
    OPC_SET_LO = 4'd10
  } mdu_op_e;

  function automatic logic op_is_mul(input logic [3:0] c);
    return c <= 4'd6;
  endfunction

  function automatic logic op_is_div(input logic [3:0] c);
    return (c == 4'd7) || (c == 4'd8);
  endfunction

  function automatic logic op_is_uns(input logic [3:0] c);
    return (c == 4'd1) || (c == 4'd3) || (c == 4'd5) || (c == 4'd8);
  endfunction
endpackage

// File: rtl/mdu_mul_seq.sv
module mdu_mul_seq #(
  parameter int W     = 32,
  parameter int DIGIT = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           sgn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           done,
  output logic [2*W-1:0] result
);
  localparam int PW    = 2 * W;
  localparam int STEPS = W / DIGIT;
  localparam int CW    = $clog2(STEPS + 1) + 1;
  localparam logic [CW-1:0] PH_LAST = CW'(STEPS - 1);
  localparam logic [CW-1:0] PH_FIX  = CW'(STEPS);

  logic          active, sgn_q, neg_q;
  logic [W-1:0]  ma, mb, mb_sh;
  logic [PW-1:0] acc, part, acc_nx;
  logic [CW-1:0] ph;
  logic          mag_end, fix_ph;

  always_comb begin
    mb_sh   = mb >> (DIGIT * ph);
    part    = ({{W{1'b0}}, ma} * {{(PW-DIGIT){1'b0}}, mb_sh[DIGIT-1:0]}) << (DIGIT * ph);
    acc_nx  = acc + part;
    mag_end = active && (ph == PH_LAST);
    fix_ph  = active && sgn_q && (ph == PH_FIX);
    done    = (mag_end && !sgn_q) || fix_ph;
    result  = fix_ph ? (neg_q ? -acc : acc) : acc_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sgn_q  <= 1'b0;
      neg_q  <= 1'b0;
      ma     <= '0;
      mb     <= '0;
      acc    <= '0;
      ph     <= '0;
    end else if (start) begin
      active <= 1'b1;
      sgn_q  <= sgn;
      neg_q  <= sgn && (a[W-1] ^ b[W-1]);
      ma     <= (sgn && a[W-1]) ? -a : a;
      mb     <= (sgn && b[W-1]) ? -b : b;
      acc    <= '0;
      ph     <= '0;
    end else if (active) begin
      if (done) begin
        active <= 1'b0;
      end else begin
        acc <= acc_nx;
        ph  <= ph + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdu_div_seq.sv
module mdu_div_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sgn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 3) + 1;
  localparam logic [CW-1:0] PH_ITER_END = CW'(W);
  localparam logic [CW-1:0] PH_END      = CW'(W + 1);
  localparam logic [CW-1:0] PH_SDONE    = CW'(W + 2);

  logic          active, sgn_q, qneg, rneg;
  logic [W-1:0]  a_q, b_q, dv;
  logic [CW-1:0] ph;
  logic [W+1:0]  trial;

  always_comb begin
    trial = {1'b0, rem, quo[W-1]} - {2'b00, dv};
    done  = active && (((ph == PH_END) && !sgn_q) || (ph == PH_SDONE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sgn_q  <= 1'b0;
      qneg   <= 1'b0;
      rneg   <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      dv     <= '0;
      quo    <= '0;
      rem    <= '0;
      ph     <= '0;
    end else if (start) begin
      active <= 1'b1;
      sgn_q  <= sgn;
      qneg   <= sgn && (a[W-1] ^ b[W-1]);
      rneg   <= sgn && a[W-1];
      a_q    <= a;
      b_q    <= b;
      ph     <= '0;
    end else if (active) begin
      if (ph == '0) begin
        quo <= (sgn_q && a_q[W-1]) ? -a_q : a_q;
        dv  <= (sgn_q && b_q[W-1]) ? -b_q : b_q;
        rem <= '0;
        ph  <= ph + 1'b1;
      end else if (ph <= PH_ITER_END) begin
        if (!trial[W+1]) begin
          rem <= trial[W-1:0];
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= {rem[W-2:0], quo[W-1]};
          quo <= {quo[W-2:0], 1'b0};
        end
        ph <= ph + 1'b1;
      end else if (ph == PH_END && sgn_q) begin
        quo <= qneg ? -quo : quo;
        rem <= rneg ? -rem : rem;
        ph  <= ph + 1'b1;
      end else begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdu_acc_sat.sv
module mdu_acc_sat #(
  parameter int PW = 64
) (
  input  logic [PW-1:0] base,
  input  logic [PW-1:0] prod,
  input  logic          sub,
  input  logic          sgn,
  input  logic          sat,
  output logic [PW-1:0] sum,
  output logic          ovf
);
  localparam logic [PW-1:0] POS_MAX = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0] NEG_MAX = {1'b1, {(PW-1){1'b0}}};

  logic [PW-1:0] raw;

  always_comb begin
    raw = sub ? (base - prod) : (base + prod);
    if (sub)
      ovf = sgn && (base[PW-1] != prod[PW-1]) && (raw[PW-1] != base[PW-1]);
    else
      ovf = sgn && (base[PW-1] == prod[PW-1]) && (raw[PW-1] != base[PW-1]);
    if (ovf && sat)
      sum = base[PW-1] ? NEG_MAX : POS_MAX;
    else
      sum = raw;
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int W     = 32,
  parameter int DIGIT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         op_sat,
  output logic         busy,
  output logic         ovf_flag,
  input  logic         rd_valid,
  input  logic         rd_sel,
  output logic         rd_ready,
  output logic [W-1:0] rd_data
);
  localparam int PW = 2 * W;

  logic          busy_q;
  logic [W-1:0]  hi_q, lo_q;
  logic [3:0]    cur_op;
  logic          sat_q;
  logic          accept, start_mul, start_div, op_sgn;
  logic          mul_done, div_done;
  logic [PW-1:0] mul_res, acc_sum;
  logic [W-1:0]  div_q, div_r;
  logic          acc_ovf, acc_sub, acc_sgn;

  always_comb begin
    op_ready  = !busy_q;
    rd_ready  = !busy_q;
    busy      = busy_q;
    accept    = op_valid && op_ready;
    start_mul = accept && op_is_mul(op_code);
    start_div = accept && op_is_div(op_code);
    op_sgn    = !op_is_uns(op_code);
    acc_sub   = (cur_op == OPC_MSB_S) || (cur_op == OPC_MSB_U);
    acc_sgn   = (cur_op == OPC_MAC_S) || (cur_op == OPC_MSB_S);
    rd_data   = rd_valid ? (rd_sel ? hi_q : lo_q) : '0;
  end

  mdu_mul_seq #(.W(W), .DIGIT(DIGIT)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(start_mul), .sgn(op_sgn),
    .a(op_a), .b(op_b), .done(mul_done), .result(mul_res)
  );

  mdu_div_seq #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start_div), .sgn(op_sgn),
    .a(op_a), .b(op_b), .done(div_done), .quo(div_q), .rem(div_r)
  );

  mdu_acc_sat #(.PW(PW)) u_acc (
    .base({hi_q, lo_q}), .prod(mul_res), .sub(acc_sub), .sgn(acc_sgn),
    .sat(sat_q), .sum(acc_sum), .ovf(acc_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
      cur_op   <= '0;
      sat_q    <= 1'b0;
      ovf_flag <= 1'b0;
    end else if (accept) begin
      if (op_code == OPC_SET_HI) begin
        hi_q <= op_a;
      end else if (op_code == OPC_SET_LO) begin
        lo_q <= op_a;
      end else if (start_mul || start_div) begin
        busy_q <= 1'b1;
        cur_op <= op_code;
        sat_q  <= op_sat;
      end
    end else if (busy_q && mul_done) begin
      busy_q <= 1'b0;
      case (cur_op)
        OPC_MUL_S, OPC_MUL_U: {hi_q, lo_q} <= mul_res;
        OPC_MUL_LO:           lo_q <= mul_res[W-1:0];
        default: begin
          {hi_q, lo_q} <= acc_sum;
          ovf_flag     <= ovf_flag | acc_ovf;
        end
      endcase
    end else if (busy_q && div_done) begin
      busy_q <= 1'b0;
      hi_q   <= div_r;
      lo_q   <= div_q;
    end
  end
endmodule

// File: rtl/muldiv_check.sv
module muldiv_check #(
  parameter int W     = 32,
  parameter int DIGIT = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         op_ready,
  input logic [3:0]   op_code,
  input logic [W-1:0] op_a,
  input logic         busy,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q,
  input logic         ovf_flag
);
  localparam int CNT_W   = $clog2(W + 4) + 1;
  localparam int MUL_LAT = W / DIGIT;
  localparam int DIV_LAT = W + 2;

  logic [CNT_W-1:0] cnt_q, lat_q;
  logic             mul_q;
  logic             acc_go;

  assign acc_go = op_valid && op_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= '0;
      mul_q <= 1'b0;
    end else if (acc_go && op_code <= 4'd8) begin
      cnt_q <= '0;
      mul_q <= (op_code <= 4'd6);
      if (op_code <= 4'd6)
        lat_q <= CNT_W'(MUL_LAT) + ((op_code == 4'd1 || op_code == 4'd3 || op_code == 4'd5) ? CNT_W'(0) : CNT_W'(1));
      else
        lat_q <= CNT_W'(DIV_LAT) + ((op_code == 4'd8) ? CNT_W'(0) : CNT_W'(1));
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_mul_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && mul_q) |-> (cnt_q == lat_q));

  assert_div_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !mul_q) |-> (cnt_q == lat_q));

  assert_hold_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q)));

  assert_move_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && op_code == 4'd9) |=> ((hi_q == $past(op_a)) && $stable(lo_q) && !busy));

  assert_sticky_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  assert_unused_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_go && op_code > 4'd10) |=> ($stable(hi_q) && $stable(lo_q) && !busy && $stable(ovf_flag)));
endmodule

bind muldiv_unit muldiv_check #(.W(W), .DIGIT(DIGIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_code(op_code), .op_a(op_a), .busy(busy), .hi_q(hi_q), .lo_q(lo_q),
  .ovf_flag(ovf_flag)
);

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_sat = 1'b0, rd_valid = 1'b0, rd_sel = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        op_ready, busy, ovf_flag, rd_ready;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_errs   = 0;
  logic m_ovf  = 1'b0;

  always #4 clk = ~clk;

  muldiv_unit u_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_a(op_a), .op_b(op_b), .op_sat(op_sat),
    .busy(busy), .ovf_flag(ovf_flag), .rd_valid(rd_valid), .rd_sel(rd_sel),
    .rd_ready(rd_ready), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic        sat;
    logic [31:0] a, b, h0, l0;
  } vec_t;

  localparam vec_t VECS [15] = '{
    '{4'd0, 1'b0, 32'hFFFFFFFF, 32'h00000005, 32'h0,        32'h0},
    '{4'd1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h0},
    '{4'd2, 1'b0, 32'hFFFFFFFD, 32'h00000007, 32'h0,        32'h00000010},
    '{4'd3, 1'b0, 32'h00000001, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFF},
    '{4'd4, 1'b0, 32'h00000002, 32'h00000003, 32'h0,        32'h0},
    '{4'd5, 1'b0, 32'h00010000, 32'h00010000, 32'h0,        32'h00000001},
    '{4'd6, 1'b0, 32'h12345678, 32'hFFFFFFFE, 32'hAAAA5555, 32'h0},
    '{4'd7, 1'b0, 32'hFFFFFFF9, 32'h00000002, 32'h0,        32'h0},
    '{4'd8, 1'b0, 32'h00000064, 32'h00000007, 32'h0,        32'h0},
    '{4'd7, 1'b0, 32'h00000007, 32'hFFFFFFFE, 32'h0,        32'h0},
    '{4'd7, 1'b0, 32'h80000000, 32'hFFFFFFFF, 32'h0,        32'h0},
    '{4'd2, 1'b1, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'hFFFFFFF0},
    '{4'd4, 1'b0, 32'h00000001, 32'h00000001, 32'h80000000, 32'h0},
    '{4'd4, 1'b1, 32'h80000000, 32'h80000000, 32'h80000000, 32'h0},
    '{4'd8, 1'b0, 32'h00001234, 32'h00000000, 32'h0,        32'h0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [3:0] op);
    case (op)
      4'd1, 4'd3, 4'd5:       return 4;
      4'd0, 4'd2, 4'd4, 4'd6: return 5;
      4'd8:                   return 34;
      4'd7:                   return 35;
      default:                return 0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op, input logic sat, input logic [31:0] b);
    if (op <= 4'd1) return "R2";
    if (op == 4'd6) return "R9";
    if (op >= 4'd7) return (b == 0) ? "R6" : "R5";
    return sat ? "R8" : "R7";
  endfunction

  task automatic model(input logic [3:0] op, input logic sat, input logic [31:0] a,
                       input logic [31:0] b, inout logic [31:0] h, inout logic [31:0] l);
    longint sa, sb, q, r;
    logic [63:0] p, base;
    logic signed [65:0] w;
    logic ov;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    base = {h, l};
    case (op)
      4'd0: {h, l} = 64'(sa * sb);
      4'd1: {h, l} = {32'h0, a} * {32'h0, b};
      4'd3: {h, l} = base + {32'h0, a} * {32'h0, b};
      4'd5: {h, l} = base - {32'h0, a} * {32'h0, b};
      4'd2, 4'd4: begin
        p = 64'(sa * sb);
        if (op == 4'd2) w = $signed({{2{base[63]}}, base}) + $signed({{2{p[63]}}, p});
        else            w = $signed({{2{base[63]}}, base}) - $signed({{2{p[63]}}, p});
        ov = !(w[65:63] == 3'b000 || w[65:63] == 3'b111);
        if (ov) m_ovf = 1'b1;
        if (ov && sat) {h, l} = w[65] ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF;
        else           {h, l} = w[63:0];
      end
      4'd6: begin p = 64'(sa * sb); l = p[31:0]; end
      4'd7: begin q = sa / sb; r = sa % sb; l = q[31:0]; h = r[31:0]; end
      4'd8: begin
        if (b == 0) begin l = 32'hFFFFFFFF; h = a; end
        else begin l = a / b; h = a % b; end
      end
      4'd9:  h = a;
      4'd10: l = a;
      default: ;
    endcase
  endtask

  // Issue one operation and count the cycles busy stays high afterwards.
  task automatic do_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic s, output int lat);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_a = a; op_b = b; op_sat = s;
    while (!op_ready) @(negedge clk);
    @(posedge clk); #1;
    op_valid = 1'b0;
    lat = 0;
    while (busy) begin
      if (op_ready || rd_ready) chk("R11 ready low while busy", {62'd0, op_ready, rd_ready}, 64'd0);
      lat++;
      @(posedge clk); #1;
    end
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    @(negedge clk);
    rd_valid = 1'b1; rd_sel = sel;
    while (!rd_ready) @(negedge clk);
    #1 v = rd_data;
    @(posedge clk); #1;
    rd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    logic [31:0] vh, vl, eh, el;
    int lat;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy/ovf", {62'd0, busy, ovf_flag}, 64'd0);
    chk("R1 ready", {62'd0, op_ready, rd_ready}, 64'd3);
    rd(1'b1, vh); rd(1'b0, vl);
    chk("R1 hi:lo", {vh, vl}, 64'd0);

    // R10 register moves
    do_op(4'd10, 32'h11, 32'h0, 1'b0, lat);
    do_op(4'd9,  32'h22, 32'h0, 1'b0, lat);
    do_op(4'd9,  32'h33, 32'h0, 1'b0, lat);
    chk("R10 no busy", 64'(lat), 64'd0);
    rd(1'b1, vh); rd(1'b0, vl);
    chk("R10 hi:lo", {vh, vl}, {32'h33, 32'h11});

    // R12 unused opcode
    do_op(4'd15, 32'hDEAD, 32'hBEEF, 1'b1, lat);
    chk("R12 no busy", 64'(lat), 64'd0);
    rd(1'b1, vh); rd(1'b0, vl);
    chk("R12 hi:lo", {vh, vl}, {32'h33, 32'h11});
    chk("R12 ovf", {63'd0, ovf_flag}, 64'd0);

    // R11 a move request held while a divide runs must not land
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'd8; op_a = 32'd50; op_b = 32'd5; op_sat = 1'b0;
    @(posedge clk); #1;
    op_code = 4'd9; op_a = 32'hBAD;
    for (int i = 0; i < 10; i++) begin
      chk("R11 op_ready held low", {62'd0, op_ready, rd_ready}, 64'd0);
      @(posedge clk); #1;
    end
    op_valid = 1'b0;
    while (busy) begin @(posedge clk); #1; end
    rd(1'b1, vh); rd(1'b0, vl);
    chk("R11 result kept", {vh, vl}, {32'd0, 32'd10});

    // R6 signed divide by zero keeps its normal latency
    do_op(4'd7, 32'hFFFFFF00, 32'h0, 1'b0, lat);
    chk("R6 signed latency", 64'(lat), 64'd35);

    // Vector table
    for (int i = 0; i < 15; i++) begin
      eh = VECS[i].h0; el = VECS[i].l0;
      do_op(4'd9,  VECS[i].h0, 32'h0, 1'b0, lat);
      do_op(4'd10, VECS[i].l0, 32'h0, 1'b0, lat);
      model(VECS[i].op, VECS[i].sat, VECS[i].a, VECS[i].b, eh, el);
      do_op(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].sat, lat);
      chk((VECS[i].op >= 4'd7) ? "R4 latency" : "R3 latency", 64'(lat), 64'(exp_lat(VECS[i].op)));
      rd(1'b1, vh); rd(1'b0, vl);
      chk(req_of(VECS[i].op, VECS[i].sat, VECS[i].b), {vh, vl}, {eh, el});
      chk("R8 ovf flag", {63'd0, ovf_flag}, {63'd0, m_ovf});
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule